// File: doc/BRIEF.md
# Split-Halfword GPIO Output and Direction Registers

This block is the register file of a 32-pin general-purpose I/O bank. It keeps two 32-bit pin registers, one for the value each pin drives and one that chooses whether each pin drives at all. It turns them into the output-value and output-enable vectors at the pads. Each pin register is reached through two bus words, one for pins 0–15 and one for pins 16–31. Every write carries its own bit mask, so software can flip a single pin without reading the register first.

In every write to a split word, bits 31:16 of the write data act as per-bit enables for data bits 15:0. A data bit is stored only where its enable bit is set. The bank also reports the pad levels after a two-stage synchronizer, and it has a fixed identification word. The bus is a simple synchronous one. Read data is registered and appears one clock after the address is presented. A write takes effect on the same clock edge that samples it.

Top module: `gpio_split_regs`

## Requirements
- R1: After reset, pinOe and pinOut are all zero (every pin an input, every output value 0), and reads of offsets 0x00, 0x04, 0x08 and 0x0C return 0.
- R2: On a write to a split word, data bit i (0..15) is stored only when write bit i+16 is 1. Bits whose enable is 0 keep their previous value.
- R3: The output-value register is written at offset 0x00 for pins 0–15 and at 0x04 for pins 16–31. pinOut[n] is the stored bit for pin n from the clock edge that takes the write.
- R4: The direction register is written at offset 0x08 for pins 0–15 and at 0x0C for pins 16–31. pinOe[n] is 1 (pin drives) when the stored bit is 1, and 0 (pin is an input) when it is 0.
- R5: A read of any split word returns its 16 stored bits in bits 15:0 and zero in bits 31:16. Read data reflects the address from one clock edge earlier and the register contents from before that edge.
- R6: A read of offset 0x70 returns the 32 pad levels, one bit per pin. The levels pass through two flip-flop stages, so a level held for three clocks is visible.
- R7: A read of offset 0x78 returns 0x01000C2B, and writes to that offset change nothing.
- R8: Writes to any offset other than 0x00, 0x04, 0x08 and 0x0C leave pinOut and pinOe unchanged. Reads of any offset other than those four, 0x70 and 0x78 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte offset of the accessed word |
| busWe | input | 1 | Write strobe, sampled at the rising edge |
| busWdata | input | 32 | Write data; bits 31:16 are the per-bit mask for split words |
| busRdata | output | 32 | Registered read data |
| pinIn | input | 32 | Asynchronous pad levels |
| pinOut | output | 32 | Output value per pin |
| pinOe | output | 32 | Output enable per pin, 1 = drive |

## Verification
The assertions take for granted that busAddr and busWe are stable and known at every rising edge. They also assume that a read and a write to the same split word in one cycle returns the contents from before the write. The stimulus changes the bus and the pads only at falling edges and holds busWe low on read cycles, so every sampled address is clean. Random writes draw their address from a mix of mapped and arbitrary offsets, and random masks cover all-set, all-clear and mixed enables.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_OUT_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIR_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_IDENT  = 8'h78;

  localparam logic [BUS_W-1:0] IDENT_WORD = 32'h01000C2B;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_OUT_LO,
    RD_OUT_HI,
    RD_DIR_LO,
    RD_DIR_HI,
    RD_LEVEL,
    RD_IDENT
  } rdSel_e;

  typedef struct packed {
    logic   wrOutLo;
    logic   wrOutHi;
    logic   wrDirLo;
    logic   wrDirHi;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/gpio_masked_half.sv
module gpio_masked_half
  import gpio_split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [BUS_W-1:0]  wrWord,
  output logic [HALF_W-1:0] q
);
  logic [HALF_W-1:0] bitEn;
  logic [HALF_W-1:0] bitVal;

  assign bitEn  = wrWord[BUS_W-1:HALF_W];
  assign bitVal = wrWord[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wrEn) begin
      q <= (q & ~bitEn) | (bitVal & bitEn);
    end
  end

  // R2
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (((q ^ $past(q)) & ~$past(bitEn)) == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(q));
endmodule

// File: rtl/gpio_split_ctrl.sv
module gpio_split_ctrl
  import gpio_split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          stb
);
  always_comb begin
    stb = '{wrOutLo: 1'b0, wrOutHi: 1'b0, wrDirLo: 1'b0, wrDirHi: 1'b0,
            rdSel: RD_NONE};
    unique case (busAddr)
      OFS_OUT_LO: begin stb.wrOutLo = busWe; stb.rdSel = RD_OUT_LO; end
      OFS_OUT_HI: begin stb.wrOutHi = busWe; stb.rdSel = RD_OUT_HI; end
      OFS_DIR_LO: begin stb.wrDirLo = busWe; stb.rdSel = RD_DIR_LO; end
      OFS_DIR_HI: begin stb.wrDirHi = busWe; stb.rdSel = RD_DIR_HI; end
      OFS_LEVEL:  stb.rdSel = RD_LEVEL;
      OFS_IDENT:  stb.rdSel = RD_IDENT;
      default:    stb.rdSel = RD_NONE;
    endcase
  end

  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrOutLo, stb.wrOutHi, stb.wrDirLo, stb.wrDirHi}));

  // R8
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busWe |-> !(stb.wrOutLo | stb.wrOutHi | stb.wrDirLo | stb.wrDirHi));
endmodule

// File: rtl/gpio_split_dp.sv
module gpio_split_dp
  import gpio_split_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobes_t         stb,
  input  logic [BUS_W-1:0] busWdata,
  input  logic [BUS_W-1:0] pinIn,
  output logic [BUS_W-1:0] busRdata,
  output logic [BUS_W-1:0] pinOut,
  output logic [BUS_W-1:0] pinOe
);
  localparam int HALVES = BUS_W / HALF_W;

  logic [HALVES-1:0] outWr;
  logic [HALVES-1:0] dirWr;
  logic [BUS_W-1:0]  syncQ [SYNC_STAGES];
  logic [BUS_W-1:0]  rdNext;

  assign outWr = {stb.wrOutHi, stb.wrOutLo};
  assign dirWr = {stb.wrDirHi, stb.wrDirLo};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    gpio_masked_half u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrEn   (outWr[h]),
      .wrWord (busWdata),
      .q      (pinOut[h*HALF_W +: HALF_W])
    );
    gpio_masked_half u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrEn   (dirWr[h]),
      .wrWord (busWdata),
      .q      (pinOe[h*HALF_W +: HALF_W])
    );
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncQ[s] <= '0;
      end else if (s == 0) begin
        syncQ[s] <= pinIn;
      end else begin
        syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_OUT_LO: rdNext = {{HALF_W{1'b0}}, pinOut[HALF_W-1:0]};
      RD_OUT_HI: rdNext = {{HALF_W{1'b0}}, pinOut[BUS_W-1:HALF_W]};
      RD_DIR_LO: rdNext = {{HALF_W{1'b0}}, pinOe[HALF_W-1:0]};
      RD_DIR_HI: rdNext = {{HALF_W{1'b0}}, pinOe[BUS_W-1:HALF_W]};
      RD_LEVEL:  rdNext = syncQ[SYNC_STAGES-1];
      RD_IDENT:  rdNext = IDENT_WORD;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busRdata <= '0;
    end else begin
      busRdata <= rdNext;
    end
  end

  // R5
  dir_hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdSel == RD_DIR_HI) |=> (busRdata == {{HALF_W{1'b0}}, $past(pinOe[BUS_W-1:HALF_W])}));

  // R5
  out_lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdSel == RD_OUT_LO) |=> (busRdata == {{HALF_W{1'b0}}, $past(pinOut[HALF_W-1:0])}));

  // R7
  ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdSel == RD_IDENT) |=> (busRdata == IDENT_WORD));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdSel == RD_NONE) |=> (busRdata == '0));
endmodule

// File: rtl/gpio_split_regs.sv
module gpio_split_regs
  import gpio_split_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [BUS_W-1:0]  pinIn,
  output logic [BUS_W-1:0]  pinOut,
  output logic [BUS_W-1:0]  pinOe
);
  strobes_t stb;

  gpio_split_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  gpio_split_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe)
  );
endmodule

// File: tb/gpio_split_regs_tb.sv
module gpio_split_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mOut = '0;
  logic [31:0] mDir = '0;

  always #2 clk = ~clk;

  gpio_split_regs u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic [15:0] mergeHalf(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return {16'h0, mOut[15:0]};
      8'h04: return {16'h0, mOut[31:16]};
      8'h08: return {16'h0, mDir[15:0]};
      8'h0C: return {16'h0, mDir[31:16]};
      8'h70: return pinIn;
      8'h78: return 32'h01000C2B;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic modelWrite(logic [7:0] a, logic [31:0] w);
    case (a)
      8'h00: mOut[15:0]  = mergeHalf(mOut[15:0], w);
      8'h04: mOut[31:16] = mergeHalf(mOut[31:16], w);
      8'h08: mDir[15:0]  = mergeHalf(mDir[15:0], w);
      8'h0C: mDir[31:16] = mergeHalf(mDir[31:16], w);
      default: ;
    endcase
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] w);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = w;
    @(negedge clk);
    busWe = 1'b0;
    modelWrite(a, w);
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] r);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    @(negedge clk);
    r = busRdata;
  endtask

  task automatic readCheck(string req, logic [7:0] a);
    logic [31:0] r;
    busRead(a, r);
    check(req, r, expRead(a));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r;
    int unsigned seedVal;
    seedVal = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 pinOut", pinOut, 32'h0);
    readCheck("R1 read 0x00", 8'h00);
    readCheck("R1 read 0x04", 8'h04);
    readCheck("R1 read 0x08", 8'h08);
    readCheck("R1 read 0x0C", 8'h0C);

    // R2 masked write: only bits 0 and 5 enabled
    busWrite(8'h00, 32'h0021_FFFF);
    check("R2 masked low", pinOut, 32'h0000_0021);
    busWrite(8'h00, 32'h0001_0000);
    check("R2 clear bit0 only", pinOut, 32'h0000_0020);
    busWrite(8'h00, 32'h0000_FFFF);
    check("R2 zero mask no change", pinOut, 32'h0000_0020);

    // R3 high word drives pins 16..31
    busWrite(8'h04, 32'hFFFF_A5C3);
    check("R3 high word", pinOut, 32'hA5C3_0020);
    check("R3 pinOe untouched", pinOe, 32'h0);

    // R4 direction
    busWrite(8'h08, 32'h8001_8001);
    busWrite(8'h0C, 32'h0100_FFFF);
    check("R4 pinOe", pinOe, 32'h0100_8001);
    check("R4 pinOut untouched", pinOut, 32'hA5C3_0020);

    // R5 readback of split words
    readCheck("R5 read 0x04", 8'h04);
    readCheck("R5 read 0x08", 8'h08);
    readCheck("R5 read 0x0C", 8'h0C);

    // R6 pad levels after sync
    @(negedge clk); pinIn = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    readCheck("R6 level", 8'h70);

    // R7 identification
    readCheck("R7 ident", 8'h78);
    busWrite(8'h78, 32'hFFFF_FFFF);
    readCheck("R7 ident after write", 8'h78);
    check("R7 pinOut after ident write", pinOut, mOut);

    // R8 unmapped accesses
    busWrite(8'h10, 32'hFFFF_FFFF);
    busWrite(8'h02, 32'hFFFF_0000);
    busWrite(8'h74, 32'hFFFF_FFFF);
    check("R8 pinOut", pinOut, mOut);
    check("R8 pinOe", pinOe, mDir);
    readCheck("R8 read 0x10", 8'h10);
    readCheck("R8 read 0xFC", 8'hFC);

    // Random traffic, R2 R3 R4 R5 R8
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] w;
      int unsigned pick;
      pick = $urandom % 6;
      case (pick)
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        3: a = 8'h0C;
        default: a = 8'($urandom);
      endcase
      w = $urandom;
      if (($urandom % 5) == 0) w[31:16] = 16'hFFFF;
      if (($urandom % 7) == 0) w[31:16] = 16'h0000;
      if ($urandom % 2) begin
        busWrite(a, w);
        check("R2 random pinOut", pinOut, mOut);
        check("R4 random pinOe", pinOe, mDir);
      end else begin
        if (a == 8'h70) begin
          @(negedge clk); pinIn = $urandom;
          repeat (3) @(negedge clk);
        end
        readCheck("R5 random read", a);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule